// File: doc/BRIEF.md
# Framing Error Event Monitor

This block sits behind a T3/E3 receive framer and keeps a small host-readable event register. It watches the framer's per-bit framing-check results and flags severely errored framing. In T3 mode the test is a sliding window: too many errored framing bits among the most recent sixteen. In E3 mode the test is a run: consecutive bad frame-alignment words. It also records each moment that one of four alarm states (loss of signal, loss of frame, AIS, remote alarm) goes away.

Every bit of the register is a sticky event flag. A bit sets only on a new event, meaning a crossing or an edge. A condition that merely persists does not set it. A one-cycle read strobe clears all bits. An event that arrives in the same cycle as a read takes priority over the clear. Switching the mode select discards any partial window history and any partial run count.

Top module: `frm_evt_mon`

## Requirements
- R1: After reset `evtReg` is all zeros.
- R2: In T3 mode (`modeE3`=0), a cycle with `fbitStb`=1 sets `evtReg[0]` on the next clock edge when that strobe brings the number of errored bits (`fbitErr`=1) among the last 16 framing-bit strobes from below 3 up to 3 or more. Errors spaced so that fewer than 3 ever share a 16-strobe window do not set it.
- R3: While the errored count in the T3 window stays at 3 or more, further framing-bit strobes do not set `evtReg[0]` again after a read. Once the count drops below 3, the next crossing sets it again.
- R4: In E3 mode (`modeE3`=1), `evtReg[0]` sets on the fourth consecutive `fasStb` with `fasBad`=1. A good word (`fasBad`=0) restarts the run. Bad words beyond the fourth in an unbroken run do not set it again.
- R5: `evtReg[1]`, `evtReg[2]`, `evtReg[3]` and `evtReg[4]` set on the clock edge after `alarmLvl[0]` (LOS), `alarmLvl[1]` (LOF), `alarmLvl[2]` (AIS) and `alarmLvl[3]` (RAI) respectively fall from 1 to 0. A rising or steady alarm level has no effect.
- R6: A cycle with `rdStb`=1 and no new event clears every bit of `evtReg` at the next edge. Without a read, set bits hold.
- R7: A new event in the same cycle as `rdStb`=1 leaves its bit set.
- R8: Only the active mode's strobes count. `fasStb` is ignored in T3 mode and `fbitStb` is ignored in E3 mode.
- R9: A change of `modeE3` clears the T3 window history and the E3 run count. Strobes in the cycle of the change are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeE3 | input | 1 | 0 = T3 window test, 1 = E3 run test |
| fbitStb | input | 1 | A framing bit was checked this cycle |
| fbitErr | input | 1 | The checked framing bit was wrong |
| fasStb | input | 1 | A frame-alignment word was checked this cycle |
| fasBad | input | 1 | The checked alignment word was bad |
| alarmLvl | input | 4 | Alarm levels: [0] LOS, [1] LOF, [2] AIS, [3] RAI |
| rdStb | input | 1 | Host read of the event register (clear on read) |
| evtReg | output | 5 | [0] severe framing, [4:1] alarm-exit events |

## Verification
The bench spaces T3 errors so that only two of them ever share a 16-strobe window. A design that counted errors cumulatively instead of sliding them out would flag an event there. It reads the register while the window count stays at or above three, then feeds more errors. A design that fired on level rather than on crossing would set the bit again. In E3 mode it breaks bad runs with a good word at length three and keeps feeding bad words past four, which exposes counters that never restart or that fire on every bad word beyond the threshold. It also collides reads with events, toggles the mode between partial counts, and raises alarms without dropping them, so that a clear that beats the event, stale history across a mode switch, or edge detection on the wrong polarity would each leave a wrong bit.

// File: rtl/fem_pkg.sv
package fem_pkg;
  localparam int ALM_NUM = 4;

  typedef struct packed {
    logic               sevHit;
    logic [ALM_NUM-1:0] almExit;
  } hitStb_t;
endpackage

// File: rtl/fem_detect.sv
module fem_detect
  import fem_pkg::*;
#(
  parameter int WIN_LEN = 16,
  parameter int ERR_THR = 3,
  parameter int RUN_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeE3,
  input  logic               fbitStb,
  input  logic               fbitErr,
  input  logic               fasStb,
  input  logic               fasBad,
  input  logic [ALM_NUM-1:0] alarmLvl,
  output hitStb_t            hits
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam int RUN_W = $clog2(RUN_LEN + 1);

  logic [WIN_LEN-1:0] hist, histNext;
  logic [CNT_W-1:0]   oldCnt, newCnt;
  logic [RUN_W-1:0]   runCnt;
  logic               modePrev, modeChg;
  logic [ALM_NUM-1:0] almPrev;
  logic               t3Hit, e3Hit;

  function automatic logic [CNT_W-1:0] popCnt(input logic [WIN_LEN-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < WIN_LEN; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  assign histNext = {hist[WIN_LEN-2:0], fbitErr};
  assign oldCnt   = popCnt(hist);
  assign newCnt   = popCnt(histNext);
  assign modeChg  = modeE3 != modePrev;

  // Crossing, not level: fire only when the count moves up through the threshold.
  assign t3Hit = !modeChg && !modeE3 && fbitStb &&
                 (newCnt >= CNT_W'(ERR_THR)) && (oldCnt < CNT_W'(ERR_THR));
  assign e3Hit = !modeChg && modeE3 && fasStb && fasBad &&
                 (runCnt == RUN_W'(RUN_LEN - 1));

  assign hits.sevHit  = t3Hit | e3Hit;
  assign hits.almExit = almPrev & ~alarmLvl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hist     <= '0;
      runCnt   <= '0;
      modePrev <= 1'b0;
      almPrev  <= '0;
    end else begin
      modePrev <= modeE3;
      almPrev  <= alarmLvl;
      if (modeChg) begin
        hist   <= '0;
        runCnt <= '0;
      end else begin
        if (!modeE3 && fbitStb) hist <= histNext;
        if (modeE3 && fasStb) begin
          if (!fasBad)                          runCnt <= '0;
          else if (runCnt != RUN_W'(RUN_LEN))   runCnt <= runCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fem_evtreg.sv
module fem_evtreg
  import fem_pkg::*;
#(
  parameter int EVT_W = ALM_NUM + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  hitStb_t          hits,
  input  logic             rdStb,
  output logic [EVT_W-1:0] evtReg
);
  logic [EVT_W-1:0] hitVec;
  assign hitVec = {hits.almExit, hits.sevHit};

  for (genvar b = 0; b < EVT_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN)          evtReg[b] <= 1'b0;
      else if (hitVec[b]) evtReg[b] <= 1'b1;   // event beats the read clear
      else if (rdStb)     evtReg[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/frm_evt_mon.sv
module frm_evt_mon
  import fem_pkg::*;
#(
  parameter int WIN_LEN = 16,
  parameter int ERR_THR = 3,
  parameter int RUN_LEN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeE3,
  input  logic               fbitStb,
  input  logic               fbitErr,
  input  logic               fasStb,
  input  logic               fasBad,
  input  logic [ALM_NUM-1:0] alarmLvl,
  input  logic               rdStb,
  output logic [ALM_NUM:0]   evtReg
);
  hitStb_t hitBus;

  fem_detect #(.WIN_LEN(WIN_LEN), .ERR_THR(ERR_THR), .RUN_LEN(RUN_LEN)) u_detect (
    .clk(clk), .rstN(rstN), .modeE3(modeE3),
    .fbitStb(fbitStb), .fbitErr(fbitErr),
    .fasStb(fasStb), .fasBad(fasBad),
    .alarmLvl(alarmLvl), .hits(hitBus)
  );

  fem_evtreg #(.EVT_W(ALM_NUM + 1)) u_evtreg (
    .clk(clk), .rstN(rstN), .hits(hitBus), .rdStb(rdStb), .evtReg(evtReg)
  );
endmodule

// File: rtl/fem_chk.sv
module fem_chk
  import fem_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               modeE3,
  input logic               fbitStb,
  input logic               fasStb,
  input logic [ALM_NUM-1:0] alarmLvl,
  input logic               rdStb,
  input hitStb_t            hitBus,
  input logic [ALM_NUM:0]   evtReg
);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && hitBus == '0) |=> (evtReg == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb && hitBus == '0) |=> $stable(evtReg));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    hitBus.sevHit |=> evtReg[0]);

  assert_active_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtReg[0]) |-> $past(modeE3 ? fasStb : fbitStb));

  for (genvar k = 0; k < ALM_NUM; k++) begin : g_alm
    assert_alarm_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $fell(alarmLvl[k])) |=> evtReg[k+1]);
  end
endmodule

bind frm_evt_mon fem_chk u_chk (
  .clk(clk), .rstN(rstN), .modeE3(modeE3), .fbitStb(fbitStb), .fasStb(fasStb),
  .alarmLvl(alarmLvl), .rdStb(rdStb), .hitBus(hitBus), .evtReg(evtReg)
);

// File: tb/frm_evt_mon_tb.sv
`timescale 1ns/1ps
module frm_evt_mon_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeE3 = 1'b0;
  logic       fbitStb = 1'b0, fbitErr = 1'b0;
  logic       fasStb = 1'b0, fasBad = 1'b0;
  logic [3:0] alarmLvl = 4'b0;
  logic       rdStb = 1'b0;
  logic [4:0] evtReg;

  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frm_evt_mon u_dut (
    .clk(clk), .rstN(rstN), .modeE3(modeE3), .fbitStb(fbitStb), .fbitErr(fbitErr),
    .fasStb(fasStb), .fasBad(fasBad), .alarmLvl(alarmLvl), .rdStb(rdStb), .evtReg(evtReg)
  );

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: evtReg=%b expected %b", req, got, exp);
    end
  endtask

  // All drives happen at negedge; one posedge later the register is sampled.
  task automatic tick();
    @(posedge clk); @(negedge clk);
    fbitStb = 0; fasStb = 0; rdStb = 0;
  endtask
  task automatic fbit(input logic err);
    fbitStb = 1; fbitErr = err; tick();
  endtask
  task automatic fas(input logic bad);
    fasStb = 1; fasBad = bad; tick();
  endtask
  task automatic rd();
    rdStb = 1; tick();
  endtask
  task automatic setMode(input logic e3);
    modeE3 = e3; tick();
  endtask
  task automatic flushT3();
    for (int i = 0; i < 16; i++) fbit(0);
    rd();
  endtask

  task automatic t_reset();
    check("R1 reset", evtReg, 5'b0);
  endtask

  task automatic t_t3Cross();
    setMode(0);
    fbit(1); fbit(0); fbit(1);
    check("R2 two errors", evtReg, 5'b0);
    fbit(1);
    check("R2 third error", evtReg, 5'b00001);
    tick(); tick();
    check("R6 hold", evtReg, 5'b00001);
    rd();
    check("R6 read clear", evtReg, 5'b0);
    fbit(1); fbit(1);
    check("R3 persisting", evtReg, 5'b0);
    flushT3();
    fbit(1); fbit(1);
    check("R3 rearm two", evtReg, 5'b0);
    fbit(1);
    check("R3 rearm third", evtReg, 5'b00001);
    rd(); flushT3();
  endtask

  task automatic t_t3Slide();
    fbit(1);
    for (int i = 0; i < 15; i++) fbit(0);
    fbit(1);
    for (int i = 0; i < 14; i++) fbit(0);
    fbit(1);
    check("R2 sliding window", evtReg, 5'b0);
    flushT3();
  endtask

  task automatic t_e3Run();
    setMode(1);
    fas(1); fas(1); fas(1); fas(0);
    fas(1); fas(1); fas(1);
    check("R4 good restarts", evtReg, 5'b0);
    fas(1);
    check("R4 fourth bad", evtReg, 5'b00001);
    rd();
    fas(1); fas(1);
    check("R4 beyond four", evtReg, 5'b0);
    fas(0); fas(1); fas(1); fas(1); fas(1);
    check("R4 new run", evtReg, 5'b00001);
    rd(); fas(0);
  endtask

  task automatic t_ignore();
    fbit(1); fbit(1); fbit(1);
    check("R8 fbit ignored in E3", evtReg, 5'b0);
    setMode(0);
    fas(1); fas(1); fas(1); fas(1);
    check("R8 fas ignored in T3", evtReg, 5'b0);
    flushT3();
  endtask

  task automatic t_modeChg();
    fbit(1); fbit(1);
    setMode(1); setMode(0);
    fbit(1);
    check("R9 T3 history cleared", evtReg, 5'b0);
    flushT3();
    setMode(1);
    fas(1); fas(1); fas(1);
    setMode(0); setMode(1);
    fas(1);
    check("R9 E3 run cleared", evtReg, 5'b0);
    fas(0);
  endtask

  task automatic t_alarms();
    for (int k = 0; k < 4; k++) begin
      alarmLvl[k] = 1'b1; tick(); tick();
      check("R5 rise no effect", evtReg, 5'b0);
      alarmLvl[k] = 1'b0; tick();
      check("R5 exit", evtReg, 5'(1 << (k + 1)));
      rd();
    end
  endtask

  task automatic t_collide();
    fas(1); fas(1); fas(1);
    fasStb = 1; fasBad = 1; rdStb = 1; tick();
    check("R7 sev wins read", evtReg, 5'b00001);
    rd(); fas(0);
    alarmLvl[2] = 1'b1; tick();
    alarmLvl[2] = 1'b0; rdStb = 1; tick();
    check("R7 alarm wins read", evtReg, 5'b01000);
    rd();
    check("R6 final clear", evtReg, 5'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_t3Cross();
    t_t3Slide();
    t_e3Run();
    t_ignore();
    t_modeChg();
    t_alarms();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule